// File: doc/BRIEF.md
# Microcode ALU Execution Unit

This block is the execute stage of a small 32-bit microcontroller that runs command-processing firmware. Each cycle it may accept one decoded instruction. The instruction is given as an opcode, a function code, a move-shift amount, two source register values and a 16-bit immediate. One clock edge later the block presents the 32-bit result and a write-enable for the destination register. The register file, instruction fetch, branching and any memory or register-bus side effects are outside this block.

There are two instruction forms. In the immediate form, the opcode selects the operation and the second operand is the immediate, zero-extended. In the two-register form, the opcode is fixed and the function code selects the operation, with the second source register taking the immediate's place. The two-register form can also reach one extra operation: a finder that returns the index of the highest set bit.

A single carry/borrow flag links a low-word add or subtract to the high-word add or subtract that follows it. This lets firmware do 64-bit arithmetic as two 32-bit steps.

Top module: `mcu_alu_exec`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid`, `out_wen` and `out_result` are cleared and the carry flag becomes 0, so a high-word add right after reset adds no carry.
- R2: An instruction sampled with `in_valid` high at a clock edge gives `out_valid` high after that same edge. When `in_valid` is low, the next `out_valid` and `out_wen` are 0. `out_wen` is never high without `out_valid`.
- R3: Immediate-form opcodes (second operand = zero-extended `in_imm`, first operand = `in_src1`): 0x01 add, 0x02 add-high, 0x03 subtract, 0x04 subtract-high, 0x05 AND, 0x06 OR, 0x07 XOR, 0x08 NOT, 0x09 shift left, 0x0a logical shift right, 0x0b arithmetic shift right, 0x0c rotate left, 0x0d 8-bit multiply, 0x0e min, 0x0f max, 0x10 compare, 0x11 move. Each of these asserts `out_wen`.
- R4: Add and subtract produce the 32-bit wrapped result and set the flag to the carry out (add) or the borrow (subtract, set when the first operand is below the second, unsigned). Add-high adds the flag in. Subtract-high subtracts it. Both high forms then store their own carry or borrow.
- R5: Every operation other than the four add/subtract opcodes, every idle cycle, and every unrecognised code leaves the flag unchanged.
- R6: AND, OR and XOR are bitwise on the two operands. NOT returns the bitwise inverse of the second operand and ignores `in_src1`.
- R7: Shift left, logical right, arithmetic right and rotate left act on `in_src1`, using only bits 4:0 of the second operand as the amount. Rotate returns the bits shifted out at the top into the low end.
- R8: The 8-bit multiply returns the unsigned product of bits 7:0 of each operand, zero-extended to 32 bits.
- R9: Min and max compare unsigned. Compare writes bit 0 = equal, bit 1 = first operand greater, bit 2 = first operand less (unsigned), with bits 31:3 zero.
- R10: Immediate-form move writes `in_imm` zero-extended and shifted left by `in_mshift`, with bits pushed past bit 31 dropped.
- R11: Opcode 0x13 is the two-register form. `in_fn` takes the same code values as R3, and the second operand is the full `in_src2`. Two-register move returns `in_src2`.
- R12: In the two-register form, function 0x14 returns the bit index of the most significant set bit of `in_src2`, or 0 when `in_src2` is 0, ignoring `in_src1`. Immediate opcode 0x14 is not an ALU operation.
- R13: Opcode 0x00, any immediate opcode outside R3, and any two-register function outside R11/R12 give `out_valid` high with `out_wen` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A decoded instruction is present |
| in_opc | input | 6 | Opcode |
| in_fn | input | 5 | Function code for the two-register form |
| in_mshift | input | 5 | Left shift applied to the immediate by move |
| in_src1 | input | 32 | First source register value |
| in_src2 | input | 32 | Second source register value |
| in_imm | input | 16 | Unsigned immediate |
| out_valid | output | 1 | Result slot is occupied |
| out_wen | output | 1 | Destination register write-enable |
| out_result | output | 32 | Result to write |

## Verification
Every result, write-enable and valid is registered once, so it is due exactly one edge after the edge that sampled the instruction. The carry flag is updated at that same edge. The bench drives each instruction at a falling edge, lets one rising edge pass, drops `in_valid`, and compares at the next falling edge, half a period clear of any register update. Carry chaining is checked only through later high-word results, with idle cycles and unrelated operations placed between the low and high steps to show that the flag is held.

// File: rtl/mcu_alu_pkg.sv
// Package: shared operation codes and code-to-operation map for the
// microcode ALU. Assumes opcode and function codes share one numbering.
package mcu_alu_pkg;

    typedef enum logic [4:0] {
        OP_NONE, OP_ADD, OP_ADDHI, OP_SUB, OP_SUBHI,
        OP_AND, OP_OR, OP_XOR, OP_NOT,
        OP_SHL, OP_USHR, OP_ISHR, OP_ROTL,
        OP_MUL8, OP_MIN, OP_MAX, OP_CMP, OP_MOV, OP_MSB
    } alu_op_e;

    localparam logic [5:0] OPC_TWO_REG = 6'h13;
    localparam logic [5:0] OPC_IMM_LAST = 6'h11;
    localparam logic [4:0] FN_MSB      = 5'h14;

    // Translate a 5-bit code (opcode or function) into an operation.
    function automatic alu_op_e code_to_op(input logic [4:0] code);
        case (code)
            5'h01: return OP_ADD;
            5'h02: return OP_ADDHI;
            5'h03: return OP_SUB;
            5'h04: return OP_SUBHI;
            5'h05: return OP_AND;
            5'h06: return OP_OR;
            5'h07: return OP_XOR;
            5'h08: return OP_NOT;
            5'h09: return OP_SHL;
            5'h0a: return OP_USHR;
            5'h0b: return OP_ISHR;
            5'h0c: return OP_ROTL;
            5'h0d: return OP_MUL8;
            5'h0e: return OP_MIN;
            5'h0f: return OP_MAX;
            5'h10: return OP_CMP;
            5'h11: return OP_MOV;
            default: return OP_NONE;
        endcase
    endfunction

    // True for the operations that write the carry/borrow flag.
    function automatic logic is_carry_op(input alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADDHI) ||
               (op == OP_SUB) || (op == OP_SUBHI);
    endfunction

endpackage

// File: rtl/mcu_alu_decode.sv
// Decode: picks the operation and builds the second operand for either
// instruction form. Purely combinational; assumes inputs are stable for
// the cycle in which in_valid is sampled.
module mcu_alu_decode
    import mcu_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int OPC_W  = 6,
    parameter int FN_W   = 5,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [OPC_W-1:0]  opc,
    input  logic [FN_W-1:0]   fn,
    input  logic [SH_W-1:0]   mshift,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] src2,
    output alu_op_e           op,
    output logic [DATA_W-1:0] opnd_b
);

    logic [DATA_W-1:0] imm_ext;
    assign imm_ext = {{(DATA_W-IMM_W){1'b0}}, imm};

    // Select the form, the operation and the second operand.
    always_comb begin
        op     = OP_NONE;
        opnd_b = imm_ext;
        if (opc == OPC_W'(OPC_TWO_REG)) begin
            opnd_b = src2;
            op     = (fn == FN_W'(FN_MSB)) ? OP_MSB : code_to_op(5'(fn));
        end else if (opc <= OPC_W'(OPC_IMM_LAST)) begin
            op = code_to_op(5'(opc));
            if (op == OP_MOV) begin
                opnd_b = imm_ext << mshift;
            end
        end
    end

endmodule

// File: rtl/mcu_alu_arith.sv
// Arithmetic group: add/subtract with carry chaining, 8-bit multiply,
// unsigned min/max and compare. Returns zero for operations outside the
// group so the top can OR the group results together.
module mcu_alu_arith
    import mcu_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MUL_W  = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);

    localparam int PROD_W = 2 * MUL_W;

    logic              cin_use;
    logic [DATA_W:0]   sum_w;
    logic [DATA_W:0]   diff_w;
    logic [PROD_W-1:0] prod;
    logic              a_lt_b;
    logic              a_eq_b;

    // Chain the stored flag into the high-word forms only.
    assign cin_use = ((op == OP_ADDHI) || (op == OP_SUBHI)) ? cin : 1'b0;
    // Extended sum and difference; the top bit is the carry or borrow.
    assign sum_w  = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin_use};
    assign diff_w = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin_use};
    assign prod   = a[MUL_W-1:0] * b[MUL_W-1:0];
    assign a_lt_b = (a < b);
    assign a_eq_b = (a == b);

    // Select the group result and the flag value to store.
    always_comb begin
        res  = '0;
        cout = 1'b0;
        case (op)
            OP_ADD, OP_ADDHI: begin
                res  = sum_w[DATA_W-1:0];
                cout = sum_w[DATA_W];
            end
            OP_SUB, OP_SUBHI: begin
                res  = diff_w[DATA_W-1:0];
                cout = diff_w[DATA_W];
            end
            OP_MUL8: res = {{(DATA_W-PROD_W){1'b0}}, prod};
            OP_MIN:  res = a_lt_b ? a : b;
            OP_MAX:  res = a_lt_b ? b : a;
            OP_CMP:  res = {{(DATA_W-3){1'b0}}, a_lt_b, (!a_lt_b && !a_eq_b), a_eq_b};
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/mcu_alu_bitops.sv
// Bitwise group: logic ops, shifts, rotate, move and most-significant-bit
// index. Shift amounts use only the low log2(DATA_W) bits of the operand.
// Returns zero for operations outside the group.
module mcu_alu_bitops
    import mcu_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res
);

    logic [SH_W-1:0]     sh;
    logic [2*DATA_W-1:0] rot_dbl;
    logic [SH_W-1:0]     msb_idx;

    assign sh = b[SH_W-1:0];
    // Doubled word shifted left; its upper half is the rotated value.
    assign rot_dbl = {a, a} << sh;

    // Scan upward so the highest set bit of b wins; zero input gives 0.
    always_comb begin
        msb_idx = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (b[i]) msb_idx = SH_W'(i);
        end
    end

    // Select the group result.
    always_comb begin
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_NOT:  res = ~b;
            OP_SHL:  res = a << sh;
            OP_USHR: res = a >> sh;
            OP_ISHR: res = DATA_W'($signed(a) >>> sh);
            OP_ROTL: res = rot_dbl[2*DATA_W-1:DATA_W];
            OP_MOV:  res = b;
            OP_MSB:  res = {{(DATA_W-SH_W){1'b0}}, msb_idx};
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/mcu_alu_exec.sv
// Top: decodes one instruction per cycle, runs both operation groups,
// registers result, write-enable and valid, and keeps the carry flag.
// Assumes a synchronous active-low reset and one-cycle result latency.
module mcu_alu_exec
    import mcu_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int OPC_W  = 6,
    parameter int FN_W   = 5,
    parameter int MUL_W  = 8,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OPC_W-1:0]  in_opc,
    input  logic [FN_W-1:0]   in_fn,
    input  logic [SH_W-1:0]   in_mshift,
    input  logic [DATA_W-1:0] in_src1,
    input  logic [DATA_W-1:0] in_src2,
    input  logic [IMM_W-1:0]  in_imm,
    output logic              out_valid,
    output logic              out_wen,
    output logic [DATA_W-1:0] out_result
);

    alu_op_e           dec_op;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] ar_res;
    logic [DATA_W-1:0] bo_res;
    logic              ar_cout;
    logic              carry_q;

    mcu_alu_decode #(
        .DATA_W(DATA_W), .IMM_W(IMM_W), .OPC_W(OPC_W), .FN_W(FN_W), .SH_W(SH_W)
    ) u_decode (
        .opc(in_opc), .fn(in_fn), .mshift(in_mshift), .imm(in_imm),
        .src2(in_src2), .op(dec_op), .opnd_b(opnd_b)
    );

    mcu_alu_arith #(.DATA_W(DATA_W), .MUL_W(MUL_W)) u_arith (
        .op(dec_op), .a(in_src1), .b(opnd_b), .cin(carry_q),
        .res(ar_res), .cout(ar_cout)
    );

    mcu_alu_bitops #(.DATA_W(DATA_W), .SH_W(SH_W)) u_bitops (
        .op(dec_op), .a(in_src1), .b(opnd_b), .res(bo_res)
    );

    // Register the merged result, write-enable and valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_wen    <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid  <= in_valid;
            out_wen    <= in_valid && (dec_op != OP_NONE);
            out_result <= in_valid ? (ar_res | bo_res) : '0;
        end
    end

    // Hold the carry/borrow flag except on add/subtract instructions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
        end else if (in_valid && is_carry_op(dec_op)) begin
            carry_q <= ar_cout;
        end
    end

    assert_wen_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_wen |-> out_valid);

    assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && is_carry_op(dec_op)) |=> $stable(carry_q));

    assert_mul_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid && dec_op == OP_MUL8))
        |-> (out_result[DATA_W-1:2*MUL_W] == '0));

    assert_cmp_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid && dec_op == OP_CMP))
        |-> ($onehot(out_result[2:0]) && out_result[DATA_W-1:3] == '0));

    assert_msb_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid && dec_op == OP_MSB))
        |-> (out_result[DATA_W-1:SH_W] == '0));

    assert_unknown_nowrite_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid && dec_op == OP_NONE))
        |-> (out_valid && !out_wen));

endmodule

// File: tb/mcu_alu_exec_tb.sv
`timescale 1ns/1ps
module mcu_alu_exec_tb;

    localparam logic [5:0] O_ADD = 6'h01, O_ADDHI = 6'h02, O_SUB = 6'h03, O_SUBHI = 6'h04;
    localparam logic [5:0] O_AND = 6'h05, O_OR = 6'h06, O_XOR = 6'h07, O_NOT = 6'h08;
    localparam logic [5:0] O_SHL = 6'h09, O_USHR = 6'h0a, O_ISHR = 6'h0b, O_ROT = 6'h0c;
    localparam logic [5:0] O_MUL = 6'h0d, O_MIN = 6'h0e, O_MAX = 6'h0f, O_CMP = 6'h10;
    localparam logic [5:0] O_MOV = 6'h11, O_TWO = 6'h13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [5:0]  in_opc = '0;
    logic [4:0]  in_fn = '0;
    logic [4:0]  in_mshift = '0;
    logic [31:0] in_src1 = '0;
    logic [31:0] in_src2 = '0;
    logic [15:0] in_imm = '0;
    logic        out_valid;
    logic        out_wen;
    logic [31:0] out_result;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    mcu_alu_exec u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opc(in_opc),
        .in_fn(in_fn), .in_mshift(in_mshift), .in_src1(in_src1),
        .in_src2(in_src2), .in_imm(in_imm), .out_valid(out_valid),
        .out_wen(out_wen), .out_result(out_result)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one instruction, wait one edge, then compare valid/wen/result.
    task automatic issue(input string req, input logic [5:0] opc, input logic [4:0] fn,
                         input logic [4:0] msh, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] imm, input logic exp_wen, input logic [31:0] exp_res);
        @(negedge clk);
        in_valid = 1'b1; in_opc = opc; in_fn = fn; in_mshift = msh;
        in_src1 = a; in_src2 = b; in_imm = imm;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {31'b0, out_valid}, 32'd1);
        check({req, " wen"}, {31'b0, out_wen}, {31'b0, exp_wen});
        if (exp_wen) check({req, " result"}, out_result, exp_res);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 valid", {31'b0, out_valid}, 32'd0);
        check("R1 wen", {31'b0, out_wen}, 32'd0);
        check("R1 result", out_result, 32'd0);
        rst_n = 1'b1;
        issue("R1 flag clear", O_ADDHI, 0, 0, 32'd2, 0, 16'd3, 1'b1, 32'd5);
    endtask

    task automatic t_carry();
        issue("R4 add wrap", O_ADD, 0, 0, 32'hFFFF_FFF0, 0, 16'h0020, 1'b1, 32'h10);
        issue("R4 addhi carry", O_ADDHI, 0, 0, 32'd5, 0, 16'd3, 1'b1, 32'd9);
        issue("R4 addhi nocarry", O_ADDHI, 0, 0, 32'd5, 0, 16'd3, 1'b1, 32'd8);
        issue("R4 sub borrow", O_SUB, 0, 0, 32'd3, 0, 16'd5, 1'b1, 32'hFFFF_FFFE);
        issue("R4 subhi borrow", O_SUBHI, 0, 0, 32'd10, 0, 16'd2, 1'b1, 32'd7);
        issue("R4 subhi clear", O_SUBHI, 0, 0, 32'd10, 0, 16'd2, 1'b1, 32'd8);
    endtask

    task automatic t_flag_hold();
        issue("R5 set", O_ADD, 0, 0, 32'hFFFF_FFFF, 0, 16'd1, 1'b1, 32'd0);
        issue("R5 and", O_AND, 0, 0, 32'hFFFF_FFFF, 0, 16'h00F0, 1'b1, 32'h00F0);
        issue("R5 unknown", 6'h12, 0, 0, 0, 0, 0, 1'b0, 0);
        @(negedge clk);
        check("R2 idle valid", {31'b0, out_valid}, 32'd0);
        check("R2 idle wen", {31'b0, out_wen}, 32'd0);
        issue("R5 addhi kept", O_ADDHI, 0, 0, 32'd0, 0, 16'd0, 1'b1, 32'd1);
    endtask

    task automatic t_logic();
        issue("R6 or", O_OR, 0, 0, 32'h1200_0000, 0, 16'h0034, 1'b1, 32'h1200_0034);
        issue("R6 xor", O_XOR, 0, 0, 32'hFFFF_00FF, 0, 16'h0F0F, 1'b1, 32'hFFFF_0FF0);
        issue("R6 not a", O_NOT, 0, 0, 32'h1234_5678, 0, 16'h00FF, 1'b1, 32'hFFFF_FF00);
        issue("R6 not b", O_NOT, 0, 0, 32'hDEAD_BEEF, 0, 16'h00FF, 1'b1, 32'hFFFF_FF00);
    endtask

    task automatic t_shift();
        issue("R7 shl mask", O_SHL, 0, 0, 32'd1, 0, 16'h0024, 1'b1, 32'h10);
        issue("R7 ushr", O_USHR, 0, 0, 32'h8000_0000, 0, 16'd4, 1'b1, 32'h0800_0000);
        issue("R7 ishr", O_ISHR, 0, 0, 32'h8000_0000, 0, 16'd4, 1'b1, 32'hF800_0000);
        issue("R7 rot", O_ROT, 0, 0, 32'h8000_0001, 0, 16'd4, 1'b1, 32'h0000_0018);
        issue("R7 rot zero", O_ROT, 0, 0, 32'hA5A5_0001, 0, 16'h0020, 1'b1, 32'hA5A5_0001);
    endtask

    task automatic t_mul_cmp();
        issue("R8 mul8", O_MUL, 0, 0, 32'h0000_01FF, 0, 16'h03FE, 1'b1, 32'h0000_FD02);
        issue("R9 min", O_MIN, 0, 0, 32'h8000_0000, 0, 16'd5, 1'b1, 32'd5);
        issue("R9 max", O_MAX, 0, 0, 32'h8000_0000, 0, 16'd5, 1'b1, 32'h8000_0000);
        issue("R9 cmp eq", O_CMP, 0, 0, 32'd7, 0, 16'd7, 1'b1, 32'd1);
        issue("R9 cmp gt", O_CMP, 0, 0, 32'h0001_0000, 0, 16'd1, 1'b1, 32'd2);
        issue("R9 cmp lt", O_CMP, 0, 0, 32'd3, 0, 16'd7, 1'b1, 32'd4);
    endtask

    task automatic t_move();
        issue("R10 mov16", O_MOV, 0, 5'd16, 32'hFFFF_FFFF, 0, 16'hABCD, 1'b1, 32'hABCD_0000);
        issue("R10 mov20", O_MOV, 0, 5'd20, 0, 0, 16'hABCD, 1'b1, 32'hBCD0_0000);
        issue("R3 mov0", O_MOV, 0, 5'd0, 0, 0, 16'h8001, 1'b1, 32'h0000_8001);
    endtask

    task automatic t_two_reg();
        issue("R11 add", O_TWO, 5'h01, 0, 32'hF000_0000, 32'h2000_0000, 16'hFFFF, 1'b1, 32'h1000_0000);
        issue("R11 carry", O_ADDHI, 0, 0, 32'd0, 0, 16'd0, 1'b1, 32'd1);
        issue("R11 mov", O_TWO, 5'h11, 5'd4, 32'd1, 32'h1234_5678, 16'd9, 1'b1, 32'h1234_5678);
        issue("R11 max", O_TWO, 5'h0f, 0, 32'h0000_0001, 32'hFFFF_0000, 0, 1'b1, 32'hFFFF_0000);
        issue("R12 msb zero", O_TWO, 5'h14, 0, 32'hFFFF_FFFF, 32'd0, 0, 1'b1, 32'd0);
        issue("R12 msb one", O_TWO, 5'h14, 0, 32'h0, 32'd1, 0, 1'b1, 32'd0);
        issue("R12 msb top", O_TWO, 5'h14, 0, 32'h0, 32'h8000_0000, 0, 1'b1, 32'd31);
        issue("R12 msb mid", O_TWO, 5'h14, 0, 32'h7, 32'h0001_2345, 0, 1'b1, 32'd16);
    endtask

    task automatic t_unknown();
        issue("R13 nop", 6'h00, 0, 0, 32'd1, 32'd1, 16'd1, 1'b0, 0);
        issue("R12 imm 0x14", 6'h14, 0, 0, 32'd1, 32'd1, 16'd1, 1'b0, 0);
        issue("R13 fn 0x12", O_TWO, 5'h12, 0, 32'd1, 32'd1, 16'd1, 1'b0, 0);
        issue("R13 fn 0x00", O_TWO, 5'h00, 0, 32'd1, 32'd1, 16'd1, 1'b0, 0);
        issue("R13 opc 0x30", 6'h30, 0, 0, 32'd1, 32'd1, 16'd1, 1'b0, 0);
    endtask

    initial begin
        t_reset();
        t_carry();
        t_flag_hold();
        t_logic();
        t_shift();
        t_mul_cmp();
        t_move();
        t_two_reg();
        t_unknown();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(8ns * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule